// File: doc/BRIEF.md
# Branch and State-Switch PC Unit

This unit resolves the control-flow operations of a 16-bit compressed instruction set. It takes one decoded operation per cycle and produces the next program counter, the next link value, the next instruction-set state, and single-cycle strobes. The operations are:

- a register-indirect branch that can switch state;
- a conditional branch;
- an unconditional branch;
- the two halves of a long branch-with-link;
- software interrupt entry;
- a high-register move or add whose destination may be the PC.

The strobes are a pipeline flush, a supervisor-mode entry, a saved-status copy, and an undefined-condition error.

The PC presented at the input already points two instructions (4 bytes) past the executing one. The unit evaluates the 4-bit branch condition itself, against the N, Z, C and V flags. Results are registered.

A two-state machine tracks each result:

- `ST_IDLE`: no result is pending.
- `ST_RESULT`: a result is valid for one cycle.

Its transitions are:

- GO, from `ST_IDLE` to `ST_RESULT`, on `op_valid`.
- STAY, from `ST_RESULT` to `ST_RESULT`, on a back-to-back `op_valid`.
- DONE, from `ST_RESULT` to `ST_IDLE`, when `op_valid` is low.

Top module: `branch_pc_unit`

## Requirements
- R1: While `rst_n` is low, `pc_next`, `lr_next`, `thumb_next`, `res_valid`, `flush`, `svc_enter`, `spsr_save` and `cond_undef` are all 0.
- R2: An operation sampled with `op_valid` high at a rising edge produces its result on the outputs after that edge, with `res_valid` high for exactly that one cycle. The strobes `flush`, `svc_enter`, `spsr_save` and `cond_undef` are never high while `res_valid` is low.
- R3: Exchange branch (`op_kind`=1) behaves as follows.
  - Bit 0 of the operand B becomes `thumb_next`: 1 selects the compressed state, 0 the full-width state.
  - `pc_next` is B with bit 0 cleared, and with bit 1 also cleared when the state is full-width. A flush is requested.
  - When `rs_is_pc` is set, bit 0 of B is cleared first.
- R4: Conditional branch (`op_kind`=2) is taken when the condition holds.
  - The condition codes, with `flags`={N,Z,C,V}, are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V).
  - When taken, `pc_next` = `pc_in` + `offset` and a flush is requested.
  - When not taken, `pc_next` = `pc_in` and there is no flush.
- R5: A conditional branch with code 14 raises `cond_undef` and is not taken. Code 15 is not taken and raises no error.
- R6: Unconditional branch (`op_kind`=3) sets `pc_next` = `pc_in` + `offset` and requests a flush.
- R7: Long-branch first half (`op_kind`=4) sets `lr_next` = `pc_in` + sext23(`offset[11:0]` << 11). `pc_next` = `pc_in` and there is no flush.
- R8: Long-branch second half (`op_kind`=5) sets `pc_next` = `lr_in` + zero-extended `offset[11:0]` and `lr_next` = (`pc_in` − 2) | 1, and requests a flush.
- R9: Software interrupt (`op_kind`=6) does all of the following:
  - sets `lr_next` = `pc_in` − 2 and `pc_next` = the trap vector (default 0x8);
  - sets `thumb_next` = 0;
  - pulses `svc_enter`, `spsr_save` and `flush` together.
- R10: High-register move (`op_kind`=7) and add (`op_kind`=8) behave as follows.
  - With `rd_is_pc` set, `pc_next` is B (move) or A+B (add), and a flush is requested.
  - Otherwise the PC is unchanged and there is no flush.
  - An operand flagged as the PC (`rd_is_pc` for A, `rs_is_pc` for B) has bit 0 cleared.
- R11: A cycle with `op_valid` low changes none of `pc_next`, `lr_next` or `thumb_next` and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A decoded operation is presented |
| op_kind | input | 4 | Operation code (see requirements) |
| cond | input | 4 | Branch condition code |
| flags | input | 4 | Status flags {N,Z,C,V} |
| thumb_in | input | 1 | Current state, 1 = compressed |
| pc_in | input | 32 | Current PC (already 4 bytes ahead) |
| lr_in | input | 32 | Current link register |
| offset | input | 32 | Branch offset or long-branch field |
| opnd_a | input | 32 | High-register destination value |
| opnd_b | input | 32 | High-register source / exchange target |
| rd_is_pc | input | 1 | Destination register is the PC |
| rs_is_pc | input | 1 | Source register is the PC |
| res_valid | output | 1 | Result valid this cycle |
| pc_next | output | 32 | Next PC |
| lr_next | output | 32 | Next link value |
| thumb_next | output | 1 | Next state bit |
| flush | output | 1 | Pipeline flush pulse |
| svc_enter | output | 1 | Supervisor-mode entry pulse |
| spsr_save | output | 1 | Saved-status copy pulse |
| cond_undef | output | 1 | Undefined condition pulse |

## Verification
The exchange branch is tried with the following targets:
- an odd target, which keeps the compressed state;
- a target whose bits 1 and 0 are 10, which must lose bit 1 in full-width state;
- a PC-sourced odd operand, which tells apart clearing bit 0 before versus after the state is chosen.

Conditional branches are run with flag sets that make the same code both taken and not taken. They include the signed codes, where N and V disagree, and codes 14 and 15, which separate the undefined error from a plain not-taken result.

The long branch is run as a negative first half and a positive first half, which exposes the sign extension from 23 bits. The second half checks the link value with bit 0 set.

High-register operations are run with and without the PC as destination. This separates a flushing write from a no-op.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    typedef enum logic [3:0] {
        OP_NONE      = 4'd0,
        OP_XBRANCH   = 4'd1,
        OP_BCOND     = 4'd2,
        OP_BRANCH    = 4'd3,
        OP_BL_FIRST  = 4'd4,
        OP_BL_SECOND = 4'd5,
        OP_TRAP      = 4'd6,
        OP_HI_MOV    = 4'd7,
        OP_HI_ADD    = 4'd8
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } res_state_e;

    localparam logic [3:0] COND_UNDEF = 4'd14;

endpackage

// File: rtl/bpu_cond_eval.sv
module bpu_cond_eval (
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       taken,
    output logic       undef
);
    logic n_f, z_f, c_f, v_f;

    assign {n_f, z_f, c_f, v_f} = flags;

    always_comb begin
        taken = 1'b0;
        undef = 1'b0;
        unique case (cond)
            4'd0:  taken = z_f;
            4'd1:  taken = !z_f;
            4'd2:  taken = c_f;
            4'd3:  taken = !c_f;
            4'd4:  taken = n_f;
            4'd5:  taken = !n_f;
            4'd6:  taken = v_f;
            4'd7:  taken = !v_f;
            4'd8:  taken = c_f && !z_f;
            4'd9:  taken = !c_f || z_f;
            4'd10: taken = (n_f == v_f);
            4'd11: taken = (n_f != v_f);
            4'd12: taken = !z_f && (n_f == v_f);
            4'd13: taken = z_f || (n_f != v_f);
            4'd14: undef = 1'b1;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/bpu_target_calc.sv
module bpu_target_calc #(
    parameter int          XLEN       = 32,
    parameter int          BL_FIELD_W = 12,
    parameter int          BL_SHIFT   = 11,
    parameter logic [31:0] TRAP_VEC   = 32'h0000_0008
) (
    input  logic [3:0]      op_kind,
    input  logic            cond_taken,
    input  logic            cond_bad,
    input  logic            thumb_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] lr_in,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            rd_is_pc,
    input  logic            rs_is_pc,
    output logic [XLEN-1:0] pc_n,
    output logic [XLEN-1:0] lr_n,
    output logic            thumb_n,
    output logic            flush_n,
    output logic            trap_n,
    output logic            undef_n
);
    import bpu_pkg::*;

    localparam int              BL_SPAN   = BL_FIELD_W + BL_SHIFT;
    localparam logic [XLEN-1:0] INSN_SIZE = XLEN'(2);

    logic [XLEN-1:0] a_m, b_m, bl_hi_ext, bl_lo_ext;

    assign a_m       = rd_is_pc ? {opnd_a[XLEN-1:1], 1'b0} : opnd_a;
    assign b_m       = rs_is_pc ? {opnd_b[XLEN-1:1], 1'b0} : opnd_b;
    assign bl_hi_ext = {{(XLEN-BL_SPAN){offset[BL_FIELD_W-1]}},
                        offset[BL_FIELD_W-1:0], {BL_SHIFT{1'b0}}};
    assign bl_lo_ext = {{(XLEN-BL_FIELD_W){1'b0}}, offset[BL_FIELD_W-1:0]};

    always_comb begin
        pc_n    = pc_in;
        lr_n    = lr_in;
        thumb_n = thumb_in;
        flush_n = 1'b0;
        trap_n  = 1'b0;
        undef_n = 1'b0;
        unique case (op_e'(op_kind))
            OP_XBRANCH: begin
                thumb_n = b_m[0];
                pc_n    = {b_m[XLEN-1:2], b_m[1] & b_m[0], 1'b0};
                flush_n = 1'b1;
            end
            OP_BCOND: begin
                if (cond_bad) begin
                    undef_n = 1'b1;
                end else if (cond_taken) begin
                    pc_n    = pc_in + offset;
                    flush_n = 1'b1;
                end
            end
            OP_BRANCH: begin
                pc_n    = pc_in + offset;
                flush_n = 1'b1;
            end
            OP_BL_FIRST: begin
                lr_n = pc_in + bl_hi_ext;
            end
            OP_BL_SECOND: begin
                pc_n    = lr_in + bl_lo_ext;
                lr_n    = (pc_in - INSN_SIZE) | XLEN'(1);
                flush_n = 1'b1;
            end
            OP_TRAP: begin
                lr_n    = pc_in - INSN_SIZE;
                pc_n    = TRAP_VEC[XLEN-1:0];
                thumb_n = 1'b0;
                trap_n  = 1'b1;
                flush_n = 1'b1;
            end
            OP_HI_MOV: begin
                if (rd_is_pc) begin
                    pc_n    = b_m;
                    flush_n = 1'b1;
                end
            end
            OP_HI_ADD: begin
                if (rd_is_pc) begin
                    pc_n    = a_m + b_m;
                    flush_n = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit #(
    parameter int          XLEN       = 32,
    parameter int          BL_FIELD_W = 12,
    parameter int          BL_SHIFT   = 11,
    parameter logic [31:0] TRAP_VEC   = 32'h0000_0008
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_kind,
    input  logic [3:0]      cond,
    input  logic [3:0]      flags,
    input  logic            thumb_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] lr_in,
    input  logic [XLEN-1:0] offset,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic            rd_is_pc,
    input  logic            rs_is_pc,
    output logic            res_valid,
    output logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] lr_next,
    output logic            thumb_next,
    output logic            flush,
    output logic            svc_enter,
    output logic            spsr_save,
    output logic            cond_undef
);
    import bpu_pkg::*;

    logic            c_taken, c_bad;
    logic [XLEN-1:0] pc_c, lr_c;
    logic            th_c, fl_c, trap_c, und_c;
    res_state_e      state_q, state_d;

    bpu_cond_eval u_cond (
        .cond  (cond),
        .flags (flags),
        .taken (c_taken),
        .undef (c_bad)
    );

    bpu_target_calc #(
        .XLEN       (XLEN),
        .BL_FIELD_W (BL_FIELD_W),
        .BL_SHIFT   (BL_SHIFT),
        .TRAP_VEC   (TRAP_VEC)
    ) u_calc (
        .op_kind    (op_kind),
        .cond_taken (c_taken),
        .cond_bad   (c_bad),
        .thumb_in   (thumb_in),
        .pc_in      (pc_in),
        .lr_in      (lr_in),
        .offset     (offset),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .rd_is_pc   (rd_is_pc),
        .rs_is_pc   (rs_is_pc),
        .pc_n       (pc_c),
        .lr_n       (lr_c),
        .thumb_n    (th_c),
        .flush_n    (fl_c),
        .trap_n     (trap_c),
        .undef_n    (und_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = op_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = op_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_next    <= '0;
            lr_next    <= '0;
            thumb_next <= 1'b0;
            flush      <= 1'b0;
            svc_enter  <= 1'b0;
            spsr_save  <= 1'b0;
            cond_undef <= 1'b0;
        end else begin
            flush      <= op_valid && fl_c;
            svc_enter  <= op_valid && trap_c;
            spsr_save  <= op_valid && trap_c;
            cond_undef <= op_valid && und_c;
            if (op_valid) begin
                pc_next    <= pc_c;
                lr_next    <= lr_c;
                thumb_next <= th_c;
            end
        end
    end

    assign res_valid = (state_q == ST_RESULT);
endmodule

// File: rtl/branch_pc_unit_chk.sv
module branch_pc_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic op_valid,
    input logic res_valid,
    input logic flush,
    input logic svc_enter,
    input logic spsr_save,
    input logic cond_undef,
    input logic thumb_next
);
    // R2
    res_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R11
    idle_no_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid && !flush && !svc_enter && !cond_undef);

    // R2
    strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !flush && !svc_enter && !spsr_save && !cond_undef);

    // R5
    undef_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cond_undef |-> !flush);

    // R9
    trap_bundle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_enter |-> spsr_save && flush && !thumb_next);
endmodule

bind branch_pc_unit branch_pc_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .res_valid  (res_valid),
    .flush      (flush),
    .svc_enter  (svc_enter),
    .spsr_save  (spsr_save),
    .cond_undef (cond_undef),
    .thumb_next (thumb_next)
);

// File: tb/branch_pc_unit_bench.sv
module branch_pc_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 19;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  cnd;
        logic [3:0]  nzcv;
        logic [31:0] pc;
        logic [31:0] lr;
        logic [31:0] off;
        logic [31:0] a;
        logic [31:0] b;
        logic        rdpc;
        logic        rspc;
        logic [31:0] epc;
        logic [31:0] elr;
        logic        eth;
        logic        efl;
        logic        esvc;
        logic        eund;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R3 odd target keeps compressed state
        '{4'd1, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h3001, 1'b0, 1'b0, 32'h3000, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},
        // R3 even target, bit1 dropped
        '{4'd1, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h3006, 1'b0, 1'b0, 32'h3004, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
        // R3 PC operand bit0 cleared first
        '{4'd1, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h1007, 1'b0, 1'b1, 32'h1004, 32'h2000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
        // R4 EQ taken backward
        '{4'd2, 4'd0, 4'b0100, 32'h1004, 32'h2000, 32'hFFFF_FFF0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0FF4, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        // R4 EQ not taken
        '{4'd2, 4'd0, 4'b0000, 32'h1004, 32'h2000, 32'hFFFF_FFF0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        // R4 HI taken
        '{4'd2, 4'd8, 4'b0010, 32'h1004, 32'h2000, 32'h20, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1024, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        // R4 GT not taken when N!=V
        '{4'd2, 4'd12, 4'b1000, 32'h1004, 32'h2000, 32'h20, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},
        // R4 LT taken when N!=V
        '{4'd2, 4'd11, 4'b1000, 32'h1004, 32'h2000, 32'h8, 32'h0, 32'h0, 1'b0, 1'b0, 32'h100C, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},
        // R5 code 14 undefined
        '{4'd2, 4'd14, 4'b0100, 32'h1004, 32'h2000, 32'h8, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5},
        // R5 code 15 plain not taken
        '{4'd2, 4'd15, 4'b1111, 32'h1004, 32'h2000, 32'h8, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd5},
        // R6 unconditional backward
        '{4'd3, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'hFFFF_F800, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0804, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd6},
        // R7 negative first half
        '{4'd4, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h801, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'hFFC0_1804, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
        // R7 positive first half
        '{4'd4, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h002, 32'h0, 32'h0, 1'b0, 1'b0, 32'h1004, 32'h2004, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},
        // R8 second half
        '{4'd5, 4'd0, 4'd0, 32'h1004, 32'h2004, 32'h010, 32'h0, 32'h0, 1'b0, 1'b0, 32'h2014, 32'h1003, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},
        // R9 trap entry
        '{4'd6, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0008, 32'h1002, 1'b0, 1'b1, 1'b1, 1'b0, 4'd9},
        // R10 move to PC
        '{4'd7, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h5555, 1'b1, 1'b0, 32'h5555, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},
        // R10 move to other register
        '{4'd7, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h0, 32'h5555, 1'b0, 1'b0, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10},
        // R10 add to PC, destination bit0 cleared
        '{4'd8, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h1005, 32'h100, 1'b1, 1'b0, 32'h1104, 32'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},
        // R10 add to other register with PC source
        '{4'd8, 4'd0, 4'd0, 32'h1004, 32'h2000, 32'h0, 32'h10, 32'h1005, 1'b0, 1'b1, 32'h1004, 32'h2000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_kind = '0;
    logic [3:0]  cond = '0;
    logic [3:0]  flags = '0;
    logic        thumb_in = 1'b1;
    logic [31:0] pc_in = '0, lr_in = '0, offset = '0, opnd_a = '0, opnd_b = '0;
    logic        rd_is_pc = 1'b0, rs_is_pc = 1'b0;
    logic        res_valid, thumb_next, flush, svc_enter, spsr_save, cond_undef;
    logic [31:0] pc_next, lr_next;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_pc_unit u_branch_pc_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .cond(cond), .flags(flags), .thumb_in(thumb_in), .pc_in(pc_in),
        .lr_in(lr_in), .offset(offset), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .rd_is_pc(rd_is_pc), .rs_is_pc(rs_is_pc), .res_valid(res_valid),
        .pc_next(pc_next), .lr_next(lr_next), .thumb_next(thumb_next),
        .flush(flush), .svc_enter(svc_enter), .spsr_save(spsr_save),
        .cond_undef(cond_undef)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] pack_out();
        return {pc_next, lr_next, 28'd0, thumb_next, flush, svc_enter, cond_undef, 32'd0};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] expv, held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check({res_valid, pc_next, lr_next, thumb_next, flush, svc_enter, spsr_save, cond_undef} == '0,
              "R1", "reset outputs", pack_out(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            op_kind = VECS[i].op; cond = VECS[i].cnd; flags = VECS[i].nzcv;
            pc_in = VECS[i].pc; lr_in = VECS[i].lr; offset = VECS[i].off;
            opnd_a = VECS[i].a; opnd_b = VECS[i].b;
            rd_is_pc = VECS[i].rdpc; rs_is_pc = VECS[i].rspc; thumb_in = 1'b1;
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            expv = {VECS[i].epc, VECS[i].elr, 28'd0, VECS[i].eth, VECS[i].efl, VECS[i].esvc, VECS[i].eund, 32'd0};
            check(pack_out() == expv && res_valid && spsr_save == VECS[i].esvc,
                  $sformatf("R%0d vec%0d", VECS[i].req, i), "result", pack_out(), expv);
            held = pack_out();
            // scramble inputs while idle; R11 nothing may change
            op_kind = 4'd3; offset = 32'h40; pc_in = 32'hABC0;
            @(negedge clk);
            // R2 single-cycle pulses, R11 hold
            check(!res_valid && !flush && !svc_enter && !spsr_save && !cond_undef
                  && {pc_next, lr_next, thumb_next} == {held[127:64], held[35]},
                  "R2/R11", "after result", pack_out(), {held[127:36], 4'b1000, 32'd0});
        end
        // R2 back-to-back operations each give a result
        op_kind = 4'd3; pc_in = 32'h100; offset = 32'h10; op_valid = 1'b1;
        @(negedge clk);
        check(res_valid && flush && pc_next == 32'h110, "R2", "b2b first", {96'd0, pc_next}, 32'h110);
        pc_in = 32'h200;
        @(negedge clk);
        op_valid = 1'b0;
        check(res_valid && flush && pc_next == 32'h210, "R2", "b2b second", {96'd0, pc_next}, 32'h210);
        // R1 reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check({res_valid, pc_next, lr_next, thumb_next, flush} == '0, "R1", "re-reset", pack_out(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule